// File: doc/BRIEF.md
# Frame Address Counter with Block-Type Rollover

This block keeps the frame address used when frames are written into, or read back from, a configuration memory. That memory is split into seven block types. The address has two parts: a 20-bit frame index and a 3-bit block-type field. Each block type has its own programmed last-frame index. When the counter steps past the last frame of the current type, the index goes back to zero and the block type moves up by one. The frame index therefore counts a segmented space, not a flat one.

The limits are written through a small port that selects one block type at a time. The same limits can be read back as packed 32-bit words, through a word selector. A direct load sets the whole address in one cycle. A sticky error flag reports any attempt to move past the last block type.

Top module: `frame_addr_ctr`

## Requirements
- R1: After a synchronous reset, frame_idx, block_type, ovf_err and row_cfg are 0, every limit is 0, and rb_word reads 0 for every rb_sel value.
- R2: With lim_we high and lim_sel in 0..6, the limit of that block type takes lim_val on the next clock edge. lim_sel = 7 changes no limit.
- R3: row_cfg is high exactly when at least one of the seven limits is non-zero.
- R4: On an increment (incr high, load low, row_cfg high), if frame_idx + 1 does not exceed the limit of the current block type, frame_idx becomes frame_idx + 1 and block_type is unchanged. The comparison also holds at limit 0xFFFFF.
- R5: On an increment where frame_idx + 1 exceeds the current type's limit and block_type is below 6, frame_idx becomes 0 and block_type becomes block_type + 1.
- R6: On an increment where frame_idx + 1 exceeds the limit while block_type is 6, block_type stays 6, frame_idx becomes 0 and ovf_err is set. ovf_err then stays set until reset, and block_type never exceeds 6.
- R7: With load high, the next address is {load_btype, load_idx}, whatever incr is. A load_btype above 6 is stored as 6 and sets ovf_err, while load_idx is still taken.
- R8: While row_cfg is low, incr has no effect on the address.
- R9: place_addr equals block_type in bits [22:20] and frame_idx in bits [19:0].
- R10: For rb_sel 0, 1 and 2, rb_word packs the limits L0..L3 as follows. Word 0 is L0 in [19:0] and L1[11:0] in [31:20]. Word 1 is L1[19:12] in [7:0], L2 in [27:8] and L3[3:0] in [31:28]. Word 2 is L3[19:4] in [15:0], with 0 above.
- R11: For rb_sel 4 and 5, rb_word packs the limits L4..L6 as follows. Word 4 is L4 in [19:0] and L5[11:0] in [31:20]. Word 5 is L5[19:12] in [7:0], L6 in [27:8] and 0 in [31:28]. rb_sel 3, 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lim_we | input | 1 | Limit write strobe |
| lim_sel | input | 3 | Block type whose limit is written |
| lim_val | input | 20 | Last-frame index to store |
| load | input | 1 | Direct address load |
| load_btype | input | 3 | Block type to load |
| load_idx | input | 20 | Frame index to load |
| incr | input | 1 | Advance the address by one frame |
| rb_sel | input | 3 | Packed limit word selector |
| frame_idx | output | 20 | Current frame index |
| block_type | output | 3 | Current block type |
| place_addr | output | 23 | Combined frame address |
| ovf_err | output | 1 | Sticky overflow past the last block type |
| row_cfg | output | 1 | At least one limit is non-zero |
| rb_word | output | 32 | Selected packed limit word |

## Verification
The bench uses the design's fixed field widths, but programs small limits (3, 0, 2, 1, 0, 4, 2). With these limits the full address space is 19 frames, so an increment sweep can visit every rollover, including a type whose limit is 0, and reach the saturation at block type 6. Large patterned limits check every bit position of the packed readback words. One run with limit 0xFFFFF checks the carry out of the full 20-bit index. A reset-and-write loop over each block type on its own covers the row-configured flag for every type.

// File: rtl/fac_pkg.sv
package fac_pkg;
    localparam int IDX_W     = 20;
    localparam int TYPE_W    = 3;
    localparam int NUM_TYPES = 7;
    localparam int MAX_TYPE  = NUM_TYPES - 1;
    localparam int ADDR_W    = IDX_W + TYPE_W;
    localparam int RB_W      = 32;
    localparam int SEL_W     = 3;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [TYPE_W-1:0] btype_t;

    typedef struct packed {
        btype_t btype;
        idx_t   idx;
    } faddr_t;

    typedef logic [NUM_TYPES-1:0][IDX_W-1:0] limits_t;

    typedef enum logic [1:0] {
        MV_HOLD,
        MV_STEP,
        MV_ROLL,
        MV_SAT
    } move_e;

    // Packed readback layout; neighbours decode these bit positions.
    function automatic logic [RB_W-1:0] pack_limits(limits_t l, logic [SEL_W-1:0] sel);
        logic [RB_W-1:0] w;
        case (sel)
            3'd0:    w = {l[1][11:0], l[0]};
            3'd1:    w = {l[3][3:0], l[2], l[1][19:12]};
            3'd2:    w = {16'h0000, l[3][19:4]};
            3'd4:    w = {l[5][11:0], l[4]};
            3'd5:    w = {4'h0, l[6], l[5][19:12]};
            default: w = '0;
        endcase
        return w;
    endfunction
endpackage

// File: rtl/fac_limit_bank.sv
module fac_limit_bank
    import fac_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  idx_t             val,
    output limits_t          lims,
    output logic             any_set
);
    idx_t lim_q [NUM_TYPES];

    for (genvar g = 0; g < NUM_TYPES; g++) begin : g_lim
        always_ff @(posedge clk) begin
            if (rst) begin
                lim_q[g] <= '0;
            end else if (we && (sel == SEL_W'(g))) begin
                lim_q[g] <= val;
            end
        end
        assign lims[g] = lim_q[g];
    end

    assign any_set = |lims;
endmodule

// File: rtl/fac_addr_counter.sv
module fac_addr_counter
    import fac_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    load,
    input  faddr_t  load_addr,
    input  logic    incr,
    input  logic    enable,
    input  limits_t lims,
    output faddr_t  addr,
    output logic    err
);
    localparam btype_t MAX_BT = btype_t'(MAX_TYPE);

    faddr_t           addr_q;
    logic             err_q;
    idx_t             cur_lim;
    logic [IDX_W:0]   nxt_idx;
    move_e            move;

    always_comb begin
        cur_lim = '0;
        for (int t = 0; t < NUM_TYPES; t++) begin
            if (addr_q.btype == btype_t'(t)) cur_lim = lims[t];
        end
    end

    assign nxt_idx = {1'b0, addr_q.idx} + {{IDX_W{1'b0}}, 1'b1};

    always_comb begin
        if (!incr || !enable) begin
            move = MV_HOLD;
        end else if (nxt_idx > {1'b0, cur_lim}) begin
            move = (addr_q.btype >= MAX_BT) ? MV_SAT : MV_ROLL;
        end else begin
            move = MV_STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q <= '0;
            err_q  <= 1'b0;
        end else if (load) begin
            addr_q.idx <= load_addr.idx;
            if (load_addr.btype > MAX_BT) begin
                addr_q.btype <= MAX_BT;
                err_q        <= 1'b1;
            end else begin
                addr_q.btype <= load_addr.btype;
            end
        end else begin
            case (move)
                MV_STEP: addr_q.idx <= nxt_idx[IDX_W-1:0];
                MV_ROLL: begin
                    addr_q.idx   <= '0;
                    addr_q.btype <= addr_q.btype + btype_t'(1);
                end
                MV_SAT: begin
                    addr_q.idx   <= '0;
                    addr_q.btype <= MAX_BT;
                    err_q        <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign addr = addr_q;
    assign err  = err_q;
endmodule

// File: rtl/fac_readback.sv
module fac_readback
    import fac_pkg::*;
(
    input  limits_t          lims,
    input  logic [SEL_W-1:0] sel,
    output logic [RB_W-1:0]  word
);
    always_comb word = pack_limits(lims, sel);
endmodule

// File: rtl/frame_addr_ctr.sv
module frame_addr_ctr
    import fac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              lim_we,
    input  logic [SEL_W-1:0]  lim_sel,
    input  logic [IDX_W-1:0]  lim_val,
    input  logic              load,
    input  logic [TYPE_W-1:0] load_btype,
    input  logic [IDX_W-1:0]  load_idx,
    input  logic              incr,
    input  logic [SEL_W-1:0]  rb_sel,
    output logic [IDX_W-1:0]  frame_idx,
    output logic [TYPE_W-1:0] block_type,
    output logic [ADDR_W-1:0] place_addr,
    output logic              ovf_err,
    output logic              row_cfg,
    output logic [RB_W-1:0]   rb_word
);
    limits_t lims;
    faddr_t  cur;
    faddr_t  ld;

    assign ld.btype = load_btype;
    assign ld.idx   = load_idx;

    fac_limit_bank u_bank (
        .clk     (clk),
        .rst     (rst),
        .we      (lim_we),
        .sel     (lim_sel),
        .val     (lim_val),
        .lims    (lims),
        .any_set (row_cfg)
    );

    fac_addr_counter u_cnt (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_addr (ld),
        .incr      (incr),
        .enable    (row_cfg),
        .lims      (lims),
        .addr      (cur),
        .err       (ovf_err)
    );

    fac_readback u_rb (
        .lims (lims),
        .sel  (rb_sel),
        .word (rb_word)
    );

    assign frame_idx  = cur.idx;
    assign block_type = cur.btype;
    assign place_addr = cur;
endmodule

// File: rtl/frame_addr_ctr_chk.sv
module frame_addr_ctr_chk
    import fac_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              load,
    input logic [TYPE_W-1:0] load_btype,
    input logic [IDX_W-1:0]  load_idx,
    input logic              incr,
    input logic [IDX_W-1:0]  frame_idx,
    input logic [TYPE_W-1:0] block_type,
    input logic              ovf_err,
    input logic              row_cfg
);
    AST_TYPE_RANGE: assert property (@(posedge clk) disable iff (rst)
        block_type <= 3'd6); // R6

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        ovf_err |=> ovf_err); // R6

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
        (load && load_btype <= 3'd6) |=>
            (frame_idx == $past(load_idx) && block_type == $past(load_btype))); // R7

    AST_NO_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!row_cfg && !load) |=> ($stable(frame_idx) && $stable(block_type))); // R8

    AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (rst)
        (incr && !load && row_cfg) |=>
            (frame_idx == $past(frame_idx) + 20'd1 || frame_idx == 20'd0)); // R4
endmodule

bind frame_addr_ctr frame_addr_ctr_chk u_chk (.*);

// File: tb/frame_addr_ctr_tb.sv
`timescale 1ns/1ps
module frame_addr_ctr_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lim_we = 1'b0;
    logic [2:0]  lim_sel = '0;
    logic [19:0] lim_val = '0;
    logic        load = 1'b0;
    logic [2:0]  load_btype = '0;
    logic [19:0] load_idx = '0;
    logic        incr = 1'b0;
    logic [2:0]  rb_sel = '0;
    logic [19:0] frame_idx;
    logic [2:0]  block_type;
    logic [22:0] place_addr;
    logic        ovf_err;
    logic        row_cfg;
    logic [31:0] rb_word;

    int checks = 0;
    int failures = 0;
    int unsigned lim [7];
    int unsigned m_idx, m_type;
    int unsigned m_err;

    always #2.5 clk = ~clk;

    frame_addr_ctr u_dut (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        cyc(); cyc();
        rst = 1'b0;
        for (int i = 0; i < 7; i++) lim[i] = 0;
        m_idx = 0; m_type = 0; m_err = 0;
    endtask

    task automatic wr_lim(input int unsigned sel, input int unsigned val);
        lim_we = 1'b1; lim_sel = sel[2:0]; lim_val = val[19:0];
        cyc();
        lim_we = 1'b0;
        if (sel < 7) lim[sel] = val & 32'hFFFFF;
    endtask

    function automatic logic [31:0] exp_word(input int unsigned s);
        logic [63:0] w;
        case (s)
            0: w = lim[0] + (64'(lim[1]) << 20);
            1: w = (lim[1] >> 12) + (64'(lim[2]) << 8) + (64'(lim[3] & 15) << 28);
            2: w = lim[3] >> 4;
            4: w = lim[4] + (64'(lim[5]) << 20);
            5: w = (lim[5] >> 12) + (64'(lim[6]) << 8);
            default: w = 0;
        endcase
        return w[31:0];
    endfunction

    task automatic check_rb(input string req);
        for (int s = 0; s < 8; s++) begin
            rb_sel = s[2:0];
            #0.5;
            chk(req, rb_word, exp_word(s));
        end
    endtask

    function automatic int unsigned any_lim();
        int unsigned a = 0;
        for (int i = 0; i < 7; i++) if (lim[i] != 0) a = 1;
        return a;
    endfunction

    task automatic step_model();
        if (any_lim() != 0) begin
            if (m_idx + 1 > lim[m_type]) begin
                m_idx = 0;
                if (m_type == 6) m_err = 1;
                else m_type++;
            end else begin
                m_idx++;
            end
        end
    endtask

    task automatic check_addr(input string req);
        chk(req, frame_idx, m_idx);
        chk(req, block_type, m_type);
        chk(req, ovf_err, m_err);
        chk({req, "/R9"}, place_addr, (m_type << 20) | m_idx);
    endtask

    task automatic do_load(input int unsigned bt, input int unsigned ix, input logic with_incr);
        load = 1'b1; load_btype = bt[2:0]; load_idx = ix[19:0]; incr = with_incr;
        cyc();
        load = 1'b0; incr = 1'b0;
        m_idx = ix;
        if (bt > 6) begin m_type = 6; m_err = 1; end
        else m_type = bt;
    endtask

    initial begin
        #(200000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1;
        do_reset();
        // R1
        check_addr("R1");
        chk("R1", row_cfg, 0);
        check_rb("R1");

        // R8: increments ignored with no limits
        incr = 1'b1; cyc(); cyc(); cyc(); incr = 1'b0;
        check_addr("R8");

        // R2: selector 7 ignored; R3 stays low
        wr_lim(7, 20'hABCDE);
        chk("R2", row_cfg, 0);
        check_rb("R2");

        // R3: each type alone raises row_cfg
        for (int t = 0; t < 7; t++) begin
            do_reset();
            chk("R3", row_cfg, 0);
            wr_lim(t, 1);
            chk("R3", row_cfg, 1);
        end

        // R10 / R11: patterned limits
        do_reset();
        wr_lim(0, 20'h12345); wr_lim(1, 20'hFEDCB); wr_lim(2, 20'h0A5A5);
        wr_lim(3, 20'h5F00F); wr_lim(4, 20'hC3C3C); wr_lim(5, 20'h789AB);
        wr_lim(6, 20'h13579);
        check_rb("R10_R11");
        wr_lim(7, 20'h00000);
        check_rb("R2");

        // R7: load beats increment
        do_load(5, 20'h54321, 1'b1);
        check_addr("R7");

        // R4 R5 R6: full sweep over small limits
        do_reset();
        wr_lim(0, 3); wr_lim(1, 0); wr_lim(2, 2); wr_lim(3, 1);
        wr_lim(4, 0); wr_lim(5, 4); wr_lim(6, 2);
        do_load(0, 0, 1'b0);
        check_addr("R7");
        for (int k = 0; k < 24; k++) begin
            incr = 1'b1;
            cyc();
            step_model();
            check_addr("R4_R5_R6");
            incr = 1'b0;
            if (k % 3 == 0) begin
                cyc();
                check_addr("R4");
            end
        end

        // R6: error sticky across a load
        do_load(0, 0, 1'b0);
        check_addr("R6");
        incr = 1'b1; cyc(); step_model(); incr = 1'b0;
        check_addr("R6");

        // R7: type above 6 saturates and flags
        do_reset();
        wr_lim(2, 5);
        do_load(7, 9, 1'b0);
        check_addr("R7");

        // R4 R5: full-width limit
        do_reset();
        wr_lim(0, 20'hFFFFF);
        do_load(0, 20'hFFFFE, 1'b0);
        incr = 1'b1; cyc(); step_model();
        check_addr("R4");
        cyc(); step_model(); incr = 1'b0;
        check_addr("R5");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule